// File: doc/BRIEF.md
# USB Host Frame Timer

This block keeps the frame clock of a USB host. A single-cycle bit-time strobe drives a 14-bit count of bit times left in the current frame. When that count has reached zero, the next strobe reloads it from a software-programmed interval, advances a 16-bit frame number and raises a one-cycle start-of-frame pulse. Every frame therefore lasts interval+1 bit times.

Software writes a 14-bit interval together with a marker bit. The marker is copied into a status toggle only at a reload. Software can flip the marker with each new interval and then poll the toggle to learn when the new interval has taken effect. A write in the middle of a frame leaves the running count alone.

The timer runs only while the operational-state input is high. On the cycle that input rises, the count is loaded straight from the interval field, so the first frame after entry has the programmed length. Two read-only 32-bit status words expose the remaining count with its toggle, and the frame number. All unused bits read as zero.

Top module: `usb_frame_timer`

## Requirements
- R1: A synchronous active-high reset clears the remaining count, the toggle, the frame number and the start-of-frame pulse to zero.
- R2: While running, a bit-time strobe with a nonzero remaining count lowers the count by exactly one.
- R3: While running, a strobe that finds the remaining count at zero loads the interval field in place of decrementing. Successive start-of-frame pulses are therefore interval+1 strobes apart.
- R4: At each zero reload the toggle status bit takes the interval register's marker bit presented in that cycle.
- R5: At each zero reload the frame number advances by one, modulo 65536, and start-of-frame is high for exactly one cycle. The pulse appears in the first cycle after the strobe, together with the updated count and frame number.
- R6: While the operational-state input is low, strobes change neither count nor frame number, and no start-of-frame pulse is produced.
- R7: In the cycle the operational-state input goes from low to high, the remaining count loads the interval field. This takes priority over any strobe in that cycle, and the frame number, the toggle and start-of-frame stay unchanged.
- R8: A change of the interval field leaves the current remaining count untouched. The interval value presented in the cycle of the zero-reload strobe is the one loaded.
- R9: The remaining word carries the toggle in bit 31 and the count in bits 13:0. The frame-number word carries the number in bits 15:0. Every other bit of both words reads zero.
- R10: While running, a cycle without a strobe holds the count and the frame number and produces no start-of-frame pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | High while the host is in the operational state |
| bit_tick_i | input | 1 | Single-cycle bit-time strobe |
| ivl_i | input | 14 | Programmed frame interval |
| ivl_tgl_i | input | 1 | Marker bit written with the interval |
| sof_o | output | 1 | One-cycle start-of-frame pulse |
| remain_word_o | output | 32 | Status word: toggle in bit 31, remaining count in bits 13:0 |
| fnum_word_o | output | 32 | Status word: frame number in bits 15:0 |

## Verification
Two events can fall in the same cycle and need checking there.

The first is a software rewrite of the interval arriving on the very strobe that reloads the count. The bench sets a new interval and marker on the zero-count strobe. It expects that new value, not the previous one, in the count on the following cycle.

The second is entry into the operational state together with a strobe that finds the count at zero. The bench raises the state input and the strobe in one cycle. It judges the result by the count equalling the interval, no start-of-frame pulse, and an unchanged frame number.

// File: rtl/usbft_pkg.sv
package usbft_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_DEC    = 2'd1,
    ACT_RELOAD = 2'd2,
    ACT_ENTER  = 2'd3
  } rem_act_e;

  // Pick the remaining-counter action; entry outranks a strobe.
  function automatic rem_act_e pick_act(input logic running,
                                        input logic entering,
                                        input logic tick,
                                        input logic at_zero);
    rem_act_e a;
    a = ACT_HOLD;
    if (entering)
      a = ACT_ENTER;
    else if (running && tick)
      a = at_zero ? ACT_RELOAD : ACT_DEC;
    return a;
  endfunction

endpackage

// File: rtl/ft_run_edge.sv
module ft_run_edge (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic steady_o,
  output logic enter_o
);

  logic run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= run_i;
  end

  assign enter_o  = run_i & ~run_q;
  assign steady_o = run_i & run_q;

endmodule

// File: rtl/ft_remaining_ctr.sv
module ft_remaining_ctr
  import usbft_pkg::*;
#(
  parameter int REM_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             steady_i,
  input  logic             enter_i,
  input  logic             tick_i,
  input  logic [REM_W-1:0] ivl_i,
  input  logic             ivl_tgl_i,
  output logic [REM_W-1:0] rem_o,
  output logic             tgl_o,
  output logic             wrap_o
);

  localparam logic [REM_W-1:0] REM_ZERO = '0;
  localparam logic [REM_W-1:0] REM_ONE  = REM_W'(1);

  rem_act_e         act;
  logic [REM_W-1:0] rem_q;
  logic             tgl_q;

  always_comb begin
    act = pick_act(steady_i, enter_i, tick_i, rem_q == REM_ZERO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= REM_ZERO;
      tgl_q <= 1'b0;
    end else begin
      unique case (act)
        ACT_DEC:    rem_q <= rem_q - REM_ONE;
        ACT_RELOAD: begin
          rem_q <= ivl_i;
          tgl_q <= ivl_tgl_i;
        end
        ACT_ENTER:  rem_q <= ivl_i;
        default:    rem_q <= rem_q;
      endcase
    end
  end

  assign rem_o  = rem_q;
  assign tgl_o  = tgl_q;
  assign wrap_o = (act == ACT_RELOAD);

endmodule

// File: rtl/ft_frame_number.sv
module ft_frame_number #(
  parameter int FN_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv_i,
  output logic [FN_W-1:0] fnum_o,
  output logic            sof_o
);

  localparam logic [FN_W-1:0] FN_ONE = FN_W'(1);

  logic [FN_W-1:0] fnum_q;
  logic            sof_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fnum_q <= '0;
      sof_q  <= 1'b0;
    end else begin
      sof_q <= adv_i;
      if (adv_i) fnum_q <= fnum_q + FN_ONE;
    end
  end

  assign fnum_o = fnum_q;
  assign sof_o  = sof_q;

endmodule

// File: rtl/ft_status_pack.sv
module ft_status_pack #(
  parameter int REM_W   = 14,
  parameter int FN_W    = 16,
  parameter int WORD_W  = 32,
  parameter int TGL_BIT = 31
) (
  input  logic [REM_W-1:0]  rem_i,
  input  logic              tgl_i,
  input  logic [FN_W-1:0]   fnum_i,
  output logic [WORD_W-1:0] rem_word_o,
  output logic [WORD_W-1:0] fn_word_o
);

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (i < REM_W) begin : g_rem
      assign rem_word_o[i] = rem_i[i];
    end else if (i == TGL_BIT) begin : g_tgl
      assign rem_word_o[i] = tgl_i;
    end else begin : g_rres
      assign rem_word_o[i] = 1'b0;
    end

    if (i < FN_W) begin : g_fn
      assign fn_word_o[i] = fnum_i[i];
    end else begin : g_fres
      assign fn_word_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int REM_W   = 14,
  parameter int FN_W    = 16,
  parameter int WORD_W  = 32,
  parameter int TGL_BIT = WORD_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              bit_tick_i,
  input  logic [REM_W-1:0]  ivl_i,
  input  logic              ivl_tgl_i,
  output logic              sof_o,
  output logic [WORD_W-1:0] remain_word_o,
  output logic [WORD_W-1:0] fnum_word_o
);

  logic             steady;
  logic             enter;
  logic [REM_W-1:0] rem;
  logic             tgl;
  logic             wrap;
  logic [FN_W-1:0]  fnum;

  ft_run_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .run_i    (run_i),
    .steady_o (steady),
    .enter_o  (enter)
  );

  ft_remaining_ctr #(.REM_W(REM_W)) u_rem (
    .clk       (clk),
    .rst       (rst),
    .steady_i  (steady),
    .enter_i   (enter),
    .tick_i    (bit_tick_i),
    .ivl_i     (ivl_i),
    .ivl_tgl_i (ivl_tgl_i),
    .rem_o     (rem),
    .tgl_o     (tgl),
    .wrap_o    (wrap)
  );

  ft_frame_number #(.FN_W(FN_W)) u_fn (
    .clk    (clk),
    .rst    (rst),
    .adv_i  (wrap),
    .fnum_o (fnum),
    .sof_o  (sof_o)
  );

  ft_status_pack #(
    .REM_W   (REM_W),
    .FN_W    (FN_W),
    .WORD_W  (WORD_W),
    .TGL_BIT (TGL_BIT)
  ) u_pack (
    .rem_i      (rem),
    .tgl_i      (tgl),
    .fnum_i     (fnum),
    .rem_word_o (remain_word_o),
    .fn_word_o  (fnum_word_o)
  );

endmodule

// File: rtl/usb_frame_timer_chk.sv
module usb_frame_timer_chk #(
  parameter int REM_W   = 14,
  parameter int FN_W    = 16,
  parameter int WORD_W  = 32,
  parameter int TGL_BIT = WORD_W - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              run_i,
  input logic              bit_tick_i,
  input logic [REM_W-1:0]  ivl_i,
  input logic              ivl_tgl_i,
  input logic              sof_o,
  input logic [WORD_W-1:0] remain_word_o,
  input logic [WORD_W-1:0] fnum_word_o
);

  logic             was_run;
  logic [REM_W-1:0] c_rem;
  logic [FN_W-1:0]  c_fn;
  logic             c_tgl;
  logic             c_steady;

  always_ff @(posedge clk) begin
    if (rst) was_run <= 1'b0;
    else     was_run <= run_i;
  end

  assign c_rem    = remain_word_o[REM_W-1:0];
  assign c_tgl    = remain_word_o[TGL_BIT];
  assign c_fn     = fnum_word_o[FN_W-1:0];
  assign c_steady = run_i && was_run;

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (c_steady && bit_tick_i && c_rem != '0) |=> c_rem == REM_W'($past(c_rem) - 1'b1));

  // R3
  reload_val_chk: assert property (@(posedge clk) disable iff (rst)
    (c_steady && bit_tick_i && c_rem == '0) |=> c_rem == $past(ivl_i));

  // R4
  toggle_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (c_steady && bit_tick_i && c_rem == '0) |=> c_tgl == $past(ivl_tgl_i));

  // R5
  frame_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (c_steady && bit_tick_i && c_rem == '0) |=> (sof_o && c_fn == FN_W'($past(c_fn) + 1'b1)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> ($stable(remain_word_o) && $stable(fnum_word_o) && !sof_o));

  // R7
  entry_load_chk: assert property (@(posedge clk) disable iff (rst)
    (run_i && !was_run) |=> (c_rem == $past(ivl_i) && !sof_o && $stable(fnum_word_o) && $stable(c_tgl)));

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (remain_word_o[TGL_BIT-1:REM_W] == '0 && fnum_word_o[WORD_W-1:FN_W] == '0));

  // R10
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (c_steady && !bit_tick_i) |=> ($stable(remain_word_o) && $stable(fnum_word_o) && !sof_o));

endmodule

bind usb_frame_timer usb_frame_timer_chk #(
  .REM_W   (REM_W),
  .FN_W    (FN_W),
  .WORD_W  (WORD_W),
  .TGL_BIT (TGL_BIT)
) u_chk (.*);

// File: tb/usb_frame_timer_tb.sv
module usb_frame_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 200000;

  logic        clk = 1'b0;
  logic        rst;
  logic        run;
  logic        tick;
  logic [13:0] ivl;
  logic        tgl;
  logic        sof;
  logic [31:0] rw;
  logic [31:0] fw;

  int checks = 0;
  int errors = 0;
  int exp_fn = 0;
  bit done   = 1'b0;

  usb_frame_timer u_dut (
    .clk           (clk),
    .rst           (rst),
    .run_i         (run),
    .bit_tick_i    (tick),
    .ivl_i         (ivl),
    .ivl_tgl_i     (tgl),
    .sof_o         (sof),
    .remain_word_o (rw),
    .fnum_word_o   (fw)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R9 layout: toggle bit 31, count 13:0, number 15:0, rest zero
  task automatic chk_layout();
    chk("R9", "remain reserved", rw[30:14], 0);
    chk("R9", "fnum reserved", fw[31:16], 0);
  endtask

  task automatic one_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // Tick until a start-of-frame pulse; return the number of strobes used.
  task automatic run_to_sof(output int n);
    n = 0;
    do begin
      one_tick();
      n++;
    end while (!sof && n < 20000);
    if (sof) exp_fn = (exp_fn + 1) % 65536;
  endtask

  initial begin
    int n;
    rst = 1'b1; run = 1'b0; tick = 1'b0; ivl = '0; tgl = 1'b0;
    repeat (3) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    // R1 reset state
    chk("R1", "remain word", rw, 0);
    chk("R1", "fnum word", fw, 0);
    chk("R1", "sof", sof, 0);
    rst = 1'b0;
    chk_layout();

    // R6 strobes while not operational
    ivl = 14'd7;
    repeat (3) one_tick();
    chk("R6", "remain idle", rw, 0);
    chk("R6", "fnum idle", fw, 0);
    chk("R6", "sof idle", sof, 0);

    // R7 entry loads the interval, no pulse, toggle unchanged
    ivl = 14'd5; tgl = 1'b1;
    run = 1'b1;
    @(negedge clk);
    chk("R7", "entry count", rw[13:0], 5);
    chk("R7", "entry toggle", rw[31], 0);
    chk("R7", "entry fnum", fw[15:0], 0);
    chk("R7", "entry sof", sof, 0);

    // R2/R3/R4/R5 sweep over small intervals
    for (int k = 0; k < 8; k++) begin
      ivl = 14'(k); tgl = k[0];
      run_to_sof(n);
      chk("R5", "sof seen", sof, 1);
      chk("R3", "reload count", rw[13:0], k);
      chk("R4", "toggle copy", rw[31], k % 2);
      chk("R5", "fnum advance", fw[15:0], exp_fn);
      chk_layout();
      for (int j = 1; j <= k; j++) begin
        one_tick();
        chk("R2", "decrement", rw[13:0], k - j);
        chk("R5", "no sof mid-frame", sof, 0);
      end
      one_tick();
      exp_fn = (exp_fn + 1) % 65536;
      chk("R3", "period interval+1", sof, 1);
      chk("R5", "fnum per frame", fw[15:0], exp_fn);
      @(negedge clk);
      chk("R5", "sof one cycle", sof, 0);
    end

    // R10 hold without strobe
    ivl = 14'd9; tgl = 1'b0;
    run_to_sof(n);
    one_tick();
    repeat (5) @(negedge clk);
    chk("R10", "count held", rw[13:0], 8);
    chk("R10", "fnum held", fw[15:0], exp_fn);
    chk("R10", "no sof", sof, 0);

    // R8 mid-frame rewrite applies only at next reload
    ivl = 14'd2; tgl = 1'b1;
    @(negedge clk);
    chk("R8", "count untouched", rw[13:0], 8);
    chk("R8", "toggle untouched", rw[31], 0);
    run_to_sof(n);
    chk("R8", "old frame length", n, 9);
    chk("R8", "new interval loaded", rw[13:0], 2);
    chk("R4", "new toggle", rw[31], 1);

    // R8 rewrite on the reload strobe itself
    one_tick(); one_tick();
    chk("R2", "count at zero", rw[13:0], 0);
    ivl = 14'd11; tgl = 1'b0;
    one_tick();
    exp_fn = (exp_fn + 1) % 65536;
    chk("R8", "same-cycle interval", rw[13:0], 11);
    chk("R4", "same-cycle toggle", rw[31], 0);
    chk("R5", "same-cycle sof", sof, 1);

    // R7 entry coinciding with a zero-count strobe
    repeat (11) one_tick();
    chk("R2", "count drained", rw[13:0], 0);
    run = 1'b0;
    @(negedge clk);
    ivl = 14'd4; tgl = 1'b1;
    run = 1'b1;
    one_tick();
    chk("R7", "entry beats strobe", rw[13:0], 4);
    chk("R7", "entry no sof", sof, 0);
    chk("R7", "entry fnum kept", fw[15:0], exp_fn);
    chk("R7", "entry toggle kept", rw[31], 0);

    // R5 frame number wrap with a zero interval
    ivl = '0; tgl = 1'b0;
    run_to_sof(n);
    run_to_sof(n);
    chk("R3", "zero interval period", n, 1);
    tick = 1'b1;
    repeat (65535 - exp_fn) @(negedge clk);
    chk("R5", "fnum top", fw[15:0], 65535);
    @(negedge clk);
    tick = 1'b0;
    chk("R5", "fnum wrap", fw[15:0], 0);
    chk("R5", "sof at wrap", sof, 1);
    chk_layout();
    @(negedge clk);
    chk("R5", "sof drop after wrap", sof, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule